// File: doc/BRIEF.md
# ALU Operand Source Selector

This combinational block sits in front of the ALU of a single-cycle integer datapath. It looks at the opcode of the instruction being executed and picks where each of the two ALU operands comes from. The first operand, X, is taken from register source 1, the program counter, or a forced zero. The second operand, Y, is taken from register source 2, the immediate, or a forced zero. The block also drives the two 2-bit source codes so the rest of the datapath can see the choice it made.

The instruction type is decoded from the opcode field. Branches and direct jumps compute their target from the PC. The upper-immediate forms zero operand X, so the ALU passes the immediate straight through. One custom single-operand instruction zeroes operand Y. It shares the register-register opcode and is recognised by its funct7 and funct3 fields. The immediate value itself is built elsewhere and arrives on an input.

Top module: `opnd_steer`

## Requirements
- R1: When opcode bits [6:0] are 1100011 (branch) or 1101111 (direct jump), `x_sel` is 1 and `x_operand` equals `pc_value`.
- R2: When opcode bits [6:0] are 0110111 or 0010111 (upper immediate), `x_sel` is 2 and `x_operand` is zero, whatever `rs1_value` holds.
- R3: For every other opcode, including unknown ones, `x_sel` is 0 and `x_operand` equals `rs1_value`.
- R4: When opcode bits [6:0] are 0010011, 0000011 or 1100111 (immediate ALU, load, indirect jump), `y_sel` is 1 and `y_operand` equals `imm_value`.
- R5: For the branch, upper-immediate and direct-jump opcodes, `y_sel` is 1 and `y_operand` equals `imm_value`.
- R6: For the store opcode 0100011, `y_sel` is 1 (immediate) only when funct3 (bits [14:12]) is 010. Any other funct3 with this opcode gives `y_sel` 0 (rs2).
- R7: When the opcode is 0110011, funct7 (bits [31:25]) is 0000001 and funct3 is 111, `y_sel` is 2 and `y_operand` is zero, whatever `rs2_value` holds. The same funct fields under any other opcode have no such effect.
- R8: For every other instruction, `y_sel` is 0 and `y_operand` equals `rs2_value`.
- R9: Both codes take only the values 0, 1 or 2. Each operand follows its inputs within the same evaluation, with no clocked stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction being executed |
| pc_value | input | 32 | Program counter of that instruction |
| rs1_value | input | 32 | Register source 1 read value |
| rs2_value | input | 32 | Register source 2 read value |
| imm_value | input | 32 | Immediate already built for the instruction |
| x_sel | output | 2 | Operand X source: 0 rs1, 1 PC, 2 zero |
| y_sel | output | 2 | Operand Y source: 0 rs2, 1 immediate, 2 zero |
| x_operand | output | 32 | Selected operand X |
| y_operand | output | 32 | Selected operand Y |

## Verification
The bench targets the narrow store and custom-instruction rules. A design that matches only on opcode would send byte and half-word stores to the immediate. It would also zero Y for any register-register instruction, or for an immediate instruction that carries the same funct bits. Indirect jump is checked separately from direct jump: a design that lumps the two together would wrongly route the PC into X for the indirect form. Register values are changed while a zero source is selected. A mux that forwards the register instead of the constant then shows up at the operand port. Unknown opcodes are checked to fall back to both register sources.

// File: rtl/opnd_steer_pkg.sv
package opnd_steer_pkg;

  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam int F7_W  = 7;

  // opcode values that steer the selection
  localparam logic [OPC_W-1:0] OPC_REGREG = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMMALU = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_JMPIND = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JMPDIR = 7'b1101111;

  localparam logic [F3_W-1:0] F3_WORD_STORE = 3'b010;
  localparam logic [F3_W-1:0] F3_SINGLE_OP  = 3'b111;
  localparam logic [F7_W-1:0] F7_SINGLE_OP  = 7'b0000001;

  // shared source code: register, alternate (PC or immediate), zero
  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_ALT  = 2'd1,
    SRC_ZERO = 2'd2
  } src_code_e;

  typedef struct packed {
    logic regreg;
    logic immalu;
    logic load;
    logic jmpind;
    logic store;
    logic branch;
    logic upper;
    logic jmpdir;
    logic word_store;
    logic single_op;
  } insn_class_t;

endpackage

// File: rtl/opnd_type_decode.sv
module opnd_type_decode
  import opnd_steer_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] instr_word,
  output insn_class_t       cls
);

  localparam int F3_LO = 12;
  localparam int F7_LO = 25;

  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic [F7_W-1:0]  f7;

  assign opc = instr_word[OPC_W-1:0];
  assign f3  = instr_word[F3_LO +: F3_W];
  assign f7  = instr_word[F7_LO +: F7_W];

  always_comb begin
    cls            = '0;
    cls.regreg     = (opc == OPC_REGREG);
    cls.immalu     = (opc == OPC_IMMALU);
    cls.load       = (opc == OPC_LOAD);
    cls.jmpind     = (opc == OPC_JMPIND);
    cls.store      = (opc == OPC_STORE);
    cls.branch     = (opc == OPC_BRANCH);
    cls.upper      = (opc == OPC_LUI) || (opc == OPC_AUIPC);
    cls.jmpdir     = (opc == OPC_JMPDIR);
    cls.word_store = cls.store && (f3 == F3_WORD_STORE);
    cls.single_op  = cls.regreg && (f3 == F3_SINGLE_OP) && (f7 == F7_SINGLE_OP);
  end

  // at most one opcode class can be active
  always_comb begin
    AST_ONE_CLASS: assert ($onehot0({cls.regreg, cls.immalu, cls.load, cls.jmpind,
                                     cls.store, cls.branch, cls.upper, cls.jmpdir})); // R3
  end

endmodule

// File: rtl/opnd_sel_gen.sv
module opnd_sel_gen
  import opnd_steer_pkg::*;
(
  input  insn_class_t cls,
  output src_code_e   x_code,
  output src_code_e   y_code
);

  logic uses_imm;

  assign uses_imm = cls.immalu | cls.load | cls.jmpind | cls.word_store |
                    cls.branch | cls.upper | cls.jmpdir;

  // operand X: PC for pc-relative control flow, zero for upper immediates
  always_comb begin
    if (cls.branch || cls.jmpdir) x_code = SRC_ALT;
    else if (cls.upper)           x_code = SRC_ZERO;
    else                          x_code = SRC_REG;
  end

  // operand Y: zero for the single-operand instruction, then immediate, then rs2
  always_comb begin
    if (cls.single_op)  y_code = SRC_ZERO;
    else if (uses_imm)  y_code = SRC_ALT;
    else                y_code = SRC_REG;
  end

  always_comb begin
    AST_SINGLE_NEEDS_REGREG: assert (!(y_code == SRC_ZERO) || cls.regreg); // R7
    AST_UPPER_ZERO_X: assert (!cls.upper || x_code == SRC_ZERO);           // R2
  end

endmodule

// File: rtl/opnd_mux3.sv
module opnd_mux3
  import opnd_steer_pkg::*;
#(
  parameter int W = 32
) (
  input  src_code_e      sel,
  input  logic [W-1:0]   in_reg,
  input  logic [W-1:0]   in_alt,
  output logic [W-1:0]   out_val
);

  always_comb begin
    unique case (sel)
      SRC_REG:  out_val = in_reg;
      SRC_ALT:  out_val = in_alt;
      default:  out_val = '0;
    endcase
  end

endmodule

// File: rtl/opnd_steer.sv
module opnd_steer
  import opnd_steer_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] instr_word,
  input  logic [XLEN-1:0]   pc_value,
  input  logic [XLEN-1:0]   rs1_value,
  input  logic [XLEN-1:0]   rs2_value,
  input  logic [XLEN-1:0]   imm_value,
  output logic [1:0]        x_sel,
  output logic [1:0]        y_sel,
  output logic [XLEN-1:0]   x_operand,
  output logic [XLEN-1:0]   y_operand
);

  insn_class_t cls;
  src_code_e   x_code;
  src_code_e   y_code;

  opnd_type_decode #(.INSN_W(INSN_W)) u_decode (
    .instr_word (instr_word),
    .cls        (cls)
  );

  opnd_sel_gen u_selgen (
    .cls    (cls),
    .x_code (x_code),
    .y_code (y_code)
  );

  opnd_mux3 #(.W(XLEN)) u_mux_x (
    .sel     (x_code),
    .in_reg  (rs1_value),
    .in_alt  (pc_value),
    .out_val (x_operand)
  );

  opnd_mux3 #(.W(XLEN)) u_mux_y (
    .sel     (y_code),
    .in_reg  (rs2_value),
    .in_alt  (imm_value),
    .out_val (y_operand)
  );

  assign x_sel = x_code;
  assign y_sel = y_code;

  always_comb begin
    AST_X_PC:     assert (x_sel != 2'd1 || x_operand == pc_value);  // R1
    AST_X_ZERO:   assert (x_sel != 2'd2 || x_operand == '0);        // R2
    AST_X_RS1:    assert (x_sel != 2'd0 || x_operand == rs1_value); // R3
    AST_Y_IMM:    assert (y_sel != 2'd1 || y_operand == imm_value); // R4
    AST_Y_ZERO:   assert (y_sel != 2'd2 || y_operand == '0);        // R7
    AST_Y_RS2:    assert (y_sel != 2'd0 || y_operand == rs2_value); // R8
    AST_NO_CODE3: assert (x_sel != 2'd3 && y_sel != 2'd3);          // R9
  end

endmodule

// File: tb/opnd_steer_tb_top.sv
module opnd_steer_tb_top;

  localparam int NV = 17;

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                     input logic [6:0] op);
    return {f7, 5'd3, 5'd2, f3, 5'd1, op};
  endfunction

  // stimulus, expected X code, expected Y code, requirement tag
  localparam logic [31:0] V_INSN [NV] = '{
    mk(7'b0000000, 3'b000, 7'b0110011), // R8 add-like
    mk(7'b0000001, 3'b111, 7'b0110011), // R7 single operand
    mk(7'b0000001, 3'b110, 7'b0110011), // R8 funct3 differs
    mk(7'b0000000, 3'b111, 7'b0110011), // R8 funct7 differs
    mk(7'b0000000, 3'b000, 7'b0010011), // R4
    mk(7'b0000000, 3'b010, 7'b0000011), // R4 load
    mk(7'b0000000, 3'b000, 7'b1100111), // R4 indirect jump
    mk(7'b0000000, 3'b010, 7'b0100011), // R6 word store
    mk(7'b0000000, 3'b000, 7'b0100011), // R6 byte store
    mk(7'b0000000, 3'b001, 7'b0100011), // R6 half store
    mk(7'b0000000, 3'b000, 7'b1100011), // R1 R5 branch
    mk(7'b0000000, 3'b000, 7'b0110111), // R2 R5 lui
    mk(7'b0000000, 3'b000, 7'b0010111), // R2 R5 auipc
    mk(7'b0000000, 3'b000, 7'b1101111), // R1 R5 jump
    mk(7'b0000000, 3'b000, 7'b0000000), // R3 R8 unknown
    mk(7'b1111111, 3'b111, 7'b1111111), // R3 R8 unknown
    mk(7'b0000001, 3'b111, 7'b0010011)  // R7 funct under other opcode
  };
  localparam logic [1:0] V_X [NV] = '{0,0,0,0,0,0,0,0,0,0,1,2,2,1,0,0,0};
  localparam logic [1:0] V_Y [NV] = '{0,2,0,0,1,1,1,1,0,0,1,1,1,1,0,0,1};
  localparam logic [23:0] V_TAG [NV] = '{"R8 ","R7 ","R8 ","R8 ","R4 ","R4 ","R4 ",
                                          "R6 ","R6 ","R6 ","R1 ","R2 ","R2 ","R1 ",
                                          "R3 ","R3 ","R7 "};

  logic        clk;
  logic        rst_n;
  logic [31:0] instr_word, pc_value, rs1_value, rs2_value, imm_value;
  logic [1:0]  x_sel, y_sel;
  logic [31:0] x_operand, y_operand;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  opnd_steer dut_i (
    .instr_word (instr_word),
    .pc_value   (pc_value),
    .rs1_value  (rs1_value),
    .rs2_value  (rs2_value),
    .imm_value  (imm_value),
    .x_sel      (x_sel),
    .y_sel      (y_sel),
    .x_operand  (x_operand),
    .y_operand  (y_operand)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] insn, input logic [31:0] r1,
                       input logic [31:0] r2);
    @(posedge clk);
    instr_word = insn;
    rs1_value  = r1;
    rs2_value  = r2;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_op(input logic [1:0] c, input logic [31:0] rv,
                                         input logic [31:0] alt);
    return (c == 2'd0) ? rv : (c == 2'd1) ? alt : 32'h0;
  endfunction

  initial begin
    rst_n      = 1'b0;
    instr_word = '0;
    pc_value   = '0;
    rs1_value  = '0;
    rs2_value  = '0;
    imm_value  = '0;
    @(negedge clk);
    // reset state: all-zero inputs select both registers (R3, R8)
    chk("R3", "x_sel at reset", {30'd0, x_sel}, 32'd0);
    chk("R8", "y_sel at reset", {30'd0, y_sel}, 32'd0);
    chk("R9", "x_operand at reset", x_operand, 32'd0);
    @(posedge clk);
    rst_n     = 1'b1;
    pc_value  = 32'h0000_4a10;
    imm_value = 32'hffff_f800;

    for (int i = 0; i < NV; i++) begin
      drive(V_INSN[i], 32'h1111_0000 + i, 32'h2222_0000 + i);
      chk(string'(V_TAG[i]), "x_sel", {30'd0, x_sel}, {30'd0, V_X[i]});
      chk(string'(V_TAG[i]), "y_sel", {30'd0, y_sel}, {30'd0, V_Y[i]});
      chk(string'(V_TAG[i]), "x_operand", x_operand,
          exp_op(V_X[i], 32'h1111_0000 + i, pc_value));
      chk(string'(V_TAG[i]), "y_operand", y_operand,
          exp_op(V_Y[i], 32'h2222_0000 + i, imm_value));
    end

    // R2: rs1 contents must not leak through the zero source
    drive(mk(7'b0, 3'b000, 7'b0110111), 32'hdead_beef, 32'h5);
    chk("R2", "x_operand zero, rs1 set", x_operand, 32'h0);
    drive(mk(7'b0, 3'b000, 7'b0010111), 32'hffff_ffff, 32'h5);
    chk("R2", "x_operand zero, rs1 all ones", x_operand, 32'h0);

    // R7: rs2 contents must not leak through the zero source
    drive(mk(7'b0000001, 3'b111, 7'b0110011), 32'h7, 32'hcafe_f00d);
    chk("R7", "y_operand zero, rs2 set", y_operand, 32'h0);
    chk("R7", "x_operand still rs1", x_operand, 32'h7);

    // R5: branch uses PC and immediate together
    pc_value  = 32'h8000_0000;
    imm_value = 32'h0000_0ffe;
    drive(mk(7'b0, 3'b101, 7'b1100011), 32'h3, 32'h4);
    chk("R5", "branch x_operand", x_operand, 32'h8000_0000);
    chk("R5", "branch y_operand", y_operand, 32'h0000_0ffe);

    // R9: operands track register changes with no added cycle
    instr_word = mk(7'b0, 3'b000, 7'b0110011);
    rs1_value  = 32'h0bad_0001;
    rs2_value  = 32'h0bad_0002;
    #1;
    chk("R9", "x_operand same step", x_operand, 32'h0bad_0001);
    chk("R9", "y_operand same step", y_operand, 32'h0bad_0002);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule